// File: doc/BRIEF.md
# Interleaved ADC sample recombiner

Four converter cores share one input. Each core runs at a quarter of the aggregate rate, and the cores are clocked a quarter period apart. This block takes the word and strobe from each core and corrects the word with that core's own offset and gain. It holds the corrected words in a small per-core slot buffer and releases them as one stream at the full rate, in sampling order: core 0, 1, 2, 3, then core 0 again. Because each core gets its own correction, the mismatch between cores that would show up as interleaving spurs is removed before the samples are merged.

Each core has a leaky-integrator mean estimator that runs all the time. In background mode the estimator's mean becomes that core's offset coefficient. In foreground mode the offset is written through the coefficient port. In that mode a coefficient write costs one output slot, and the sample due in that slot is discarded.

Top module: `adc_ilv_recombiner`

## Requirements
- R1: Released samples always follow the core order 0, 1, 2, 3, 0, ..., whatever order the cores deliver in. `out_core_o` carries the index of the core that produced each released sample.
- R2: After reset `out_valid_o` is 0. No sample is released until every one of the four cores has delivered at least one word since reset.
- R3: With the cores delivering in turn, one core per cycle, `out_valid_o` is high on every cycle once the stream has started.
- R4: Each sample becomes y = ((x - off_k) * g_k) >>> 15, where x and off_k are 12-bit two's complement and g_k is unsigned Q1.15 (0x8000 means 1.0). After reset every off_k is 0 and every g_k is 0x8000.
- R5: A corrected value above 2047 is released as 2047, and one below -2048 is released as -2048.
- R6: In foreground mode (`bg_mode_i`=0), a cycle with `coef_we_i`=1 loads `coef_off_i` and `coef_gain_i` into the core selected by `coef_sel_i` (0 to 3). The other cores keep their coefficients.
- R7: In foreground mode, the output slot on the clock edge where `coef_we_i` is high has `out_valid_o`=0. The sample due in that slot is discarded, and the core order carries on with the next index.
- R8: Each core keeps an estimator acc that starts at 0 and takes acc + x - (acc >>> 10) for every word the core delivers, in both modes. In background mode the offset becomes acc >>> 10, including the current word, before that word is corrected.
- R9: In background mode a coefficient write loads only the gain: `coef_off_i` is ignored and the release of output samples continues.
- R10: If the slot of the next core in order is empty, release pauses and no core is skipped. Release resumes as soon as that core's word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, one output slot per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| core_data_i | input | 48 | Four 12-bit core words, core k in bits [12k+11:12k] |
| core_valid_i | input | 4 | Word strobe per core |
| bg_mode_i | input | 1 | 1: estimator owns offsets, 0: offsets written by software path |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_sel_i | input | 2 | Core index for the write |
| coef_off_i | input | 12 | Offset value, two's complement |
| coef_gain_i | input | 16 | Gain value, unsigned Q1.15 |
| out_data_o | output | 12 | Corrected sample, two's complement |
| out_valid_o | output | 1 | Sample valid |
| out_core_o | output | 2 | Index of the core that produced the sample |

## Verification
A ramp stream with identity coefficients shows whether the words are reordered, lost or repeated, and whether the output holds its full rate. A stream of per-core constants with distinct written coefficients shows whether one core's correction reaches another core's samples. Full-scale words of both signs with gains near 2.0 push the products past the 12-bit range, so saturation faults are exposed. Arrival out of order after reset, a missing core in the middle of a round, and an offset pattern that alternates by core under background estimation test the priming rule, the stall rule and the estimator arithmetic.

// File: rtl/adc_ilv_pkg.sv
package adc_ilv_pkg;
  localparam int unsigned NUM_CORES = 4;
  localparam int unsigned DATA_W    = 12;
  localparam int unsigned GAIN_W    = 16;
  localparam int unsigned GAIN_FRAC = 15;
  localparam int unsigned EST_SHIFT = 10;
endpackage

// File: rtl/adc_ilv_lane.sv
module adc_ilv_lane #(
  parameter int unsigned IDX       = 0,
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned GAIN_FRAC = 15,
  parameter int unsigned EST_SHIFT = 10,
  parameter int unsigned CORE_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              bg_mode_i,
  input  logic              coef_we_i,
  input  logic [CORE_W-1:0] coef_sel_i,
  input  logic [DATA_W-1:0] coef_off_i,
  input  logic [GAIN_W-1:0] coef_gain_i,
  output logic [DATA_W-1:0] corr_o,
  output logic              corr_valid_o
);
  localparam int unsigned ACC_W  = DATA_W + EST_SHIFT + 2;
  localparam int unsigned DIFF_W = DATA_W + 1;
  localparam int unsigned PROD_W = DIFF_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << GAIN_FRAC;
  localparam logic signed [PROD_W-1:0] SAT_MAX = (PROD_W'(1) <<< (DATA_W-1)) - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] SAT_MIN = -SAT_MAX - PROD_W'(1);

  logic signed [DATA_W-1:0] cap_q, off_q, mean_d;
  logic                     cap_v_q, sel_hit;
  logic [GAIN_W-1:0]        gain_q;
  logic signed [ACC_W-1:0]  acc_q, acc_d, x_ext, leak;
  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] diff_x, gain_x, prod, scaled;
  logic [DATA_W-1:0]        sat;

  assign sel_hit = coef_we_i && (coef_sel_i == CORE_W'(IDX));

  // leaky mean estimator
  assign x_ext  = {{(ACC_W-DATA_W){data_i[DATA_W-1]}}, data_i};
  assign leak   = acc_q >>> EST_SHIFT;
  assign acc_d  = acc_q + x_ext - leak;
  assign mean_d = DATA_W'(acc_d >>> EST_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= '0;
      cap_v_q <= 1'b0;
      acc_q   <= '0;
      off_q   <= '0;
      gain_q  <= GAIN_ONE;
    end else begin
      cap_v_q <= valid_i;
      if (valid_i) begin
        cap_q <= data_i;
        acc_q <= acc_d;
      end
      if (bg_mode_i) begin
        if (valid_i) off_q <= mean_d;
      end else if (sel_hit) begin
        off_q <= coef_off_i;
      end
      if (sel_hit) gain_q <= coef_gain_i;
    end
  end

  // correction on captured word
  assign diff   = {cap_q[DATA_W-1], cap_q} - {off_q[DATA_W-1], off_q};
  assign diff_x = PROD_W'(diff);
  assign gain_x = {{(PROD_W-GAIN_W){1'b0}}, gain_q};
  assign prod   = diff_x * gain_x;
  assign scaled = prod >>> GAIN_FRAC;

  always_comb begin
    if (scaled > SAT_MAX)      sat = SAT_MAX[DATA_W-1:0];
    else if (scaled < SAT_MIN) sat = SAT_MIN[DATA_W-1:0];
    else                       sat = scaled[DATA_W-1:0];
  end

  assign corr_o       = sat;
  assign corr_valid_o = cap_v_q;

  // R6
  fg_coef_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bg_mode_i && !sel_hit |=> $stable(off_q) && $stable(gain_q));
  // R9
  bg_off_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bg_mode_i && !valid_i |=> $stable(off_q));
endmodule

// File: rtl/adc_ilv_align.sv
module adc_ilv_align #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned CORE_W    = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CORES*DATA_W-1:0]   wr_data_i,
  input  logic [NUM_CORES-1:0]          wr_valid_i,
  input  logic                          hold_i,
  output logic [DATA_W-1:0]             out_data_o,
  output logic                          out_valid_o,
  output logic [CORE_W-1:0]             out_core_o
);
  localparam logic [CORE_W-1:0] LAST = CORE_W'(NUM_CORES-1);

  logic [DATA_W-1:0]    buf_q [NUM_CORES];
  logic [NUM_CORES-1:0] full_q, full_d, rd_hit;
  logic [CORE_W-1:0]    rd_ptr_q, out_core_q;
  logic [DATA_W-1:0]    out_data_q;
  logic                 primed_q, release_w, out_valid_q;

  assign release_w = (primed_q || (&full_q)) && full_q[rd_ptr_q];

  always_comb begin
    rd_hit = '0;
    rd_hit[rd_ptr_q] = release_w;
    for (int k = 0; k < NUM_CORES; k++) begin
      // a new word wins over the release of the old one
      full_d[k] = wr_valid_i[k] | (full_q[k] & ~rd_hit[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_CORES; k++) buf_q[k] <= '0;
      full_q      <= '0;
      rd_ptr_q    <= '0;
      primed_q    <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_core_q  <= '0;
    end else begin
      for (int k = 0; k < NUM_CORES; k++) begin
        if (wr_valid_i[k]) buf_q[k] <= wr_data_i[k*DATA_W +: DATA_W];
      end
      full_q      <= full_d;
      primed_q    <= primed_q | (&full_q);
      out_valid_q <= release_w & ~hold_i;
      if (release_w) begin
        out_data_q <= buf_q[rd_ptr_q];
        out_core_q <= rd_ptr_q;
        rd_ptr_q   <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + CORE_W'(1);
      end
    end
  end

  assign out_data_o  = out_data_q;
  assign out_valid_o = out_valid_q;
  assign out_core_o  = out_core_q;

  // R1
  core_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_q && $past(out_valid_q) |->
      out_core_q == (($past(out_core_q) == LAST) ? '0 : $past(out_core_q) + CORE_W'(1)));
  // R2
  primed_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_q |-> primed_q);
  // R7
  fg_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !out_valid_q);
  // R10
  empty_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_q[rd_ptr_q] |=> !out_valid_q && $stable(rd_ptr_q));
endmodule

// File: rtl/adc_ilv_recombiner.sv
module adc_ilv_recombiner
  import adc_ilv_pkg::*;
#(
  parameter int unsigned N_CORES = NUM_CORES,
  parameter int unsigned D_W     = DATA_W,
  parameter int unsigned G_W     = GAIN_W,
  parameter int unsigned G_FRAC  = GAIN_FRAC,
  parameter int unsigned E_SHIFT = EST_SHIFT,
  localparam int unsigned C_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CORES*D_W-1:0]   core_data_i,
  input  logic [N_CORES-1:0]       core_valid_i,
  input  logic                     bg_mode_i,
  input  logic                     coef_we_i,
  input  logic [C_W-1:0]           coef_sel_i,
  input  logic [D_W-1:0]           coef_off_i,
  input  logic [G_W-1:0]           coef_gain_i,
  output logic [D_W-1:0]           out_data_o,
  output logic                     out_valid_o,
  output logic [C_W-1:0]           out_core_o
);
  logic [N_CORES*D_W-1:0] corr_w;
  logic [N_CORES-1:0]     corr_v_w;
  logic                   hold_w;

  assign hold_w = coef_we_i & ~bg_mode_i;

  for (genvar k = 0; k < N_CORES; k++) begin : g_lane
    adc_ilv_lane #(
      .IDX(k), .DATA_W(D_W), .GAIN_W(G_W), .GAIN_FRAC(G_FRAC),
      .EST_SHIFT(E_SHIFT), .CORE_W(C_W)
    ) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .data_i      (core_data_i[k*D_W +: D_W]),
      .valid_i     (core_valid_i[k]),
      .bg_mode_i   (bg_mode_i),
      .coef_we_i   (coef_we_i),
      .coef_sel_i  (coef_sel_i),
      .coef_off_i  (coef_off_i),
      .coef_gain_i (coef_gain_i),
      .corr_o      (corr_w[k*D_W +: D_W]),
      .corr_valid_o(corr_v_w[k])
    );
  end

  adc_ilv_align #(.NUM_CORES(N_CORES), .DATA_W(D_W), .CORE_W(C_W)) u_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_data_i  (corr_w),
    .wr_valid_i (corr_v_w),
    .hold_i     (hold_w),
    .out_data_o (out_data_o),
    .out_valid_o(out_valid_o),
    .out_core_o (out_core_o)
  );
endmodule

// File: tb/adc_ilv_recombiner_tb_top.sv
module adc_ilv_recombiner_tb_top;
  localparam int NC = 4;
  localparam int DW = 12;
  localparam int GW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NC*DW-1:0] core_data = '0;
  logic [NC-1:0]    core_valid = '0;
  logic             bg_mode = 1'b0, coef_we = 1'b0;
  logic [1:0]       coef_sel = '0;
  logic [DW-1:0]    coef_off = '0;
  logic [GW-1:0]    coef_gain = '0;
  logic [DW-1:0]    out_data;
  logic             out_valid;
  logic [1:0]       out_core;

  adc_ilv_recombiner dut_i (
    .clk_i(clk), .rst_ni(rst_n), .core_data_i(core_data), .core_valid_i(core_valid),
    .bg_mode_i(bg_mode), .coef_we_i(coef_we), .coef_sel_i(coef_sel),
    .coef_off_i(coef_off), .coef_gain_i(coef_gain),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_core_o(out_core)
  );

  int checks = 0, errors = 0;
  int m_off[NC], m_gain[NC], m_acc[NC];
  int exp_q[NC][$];
  bit seen[NC];
  int exp_core = 0, out_cnt = 0, steady = 0;
  bit expect_drop = 0, bg_check = 0;
  string cur_tag = "R4";

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sx12(int v);
    int r = v & 12'hFFF;
    if (r >= 2048) r -= 4096;
    return r;
  endfunction

  function automatic int corr(int x, int off, int g);
    int v = ((x - off) * g) >>> 15;
    if (v > 2047) v = 2047;
    if (v < -2048) v = -2048;
    return v;
  endfunction

  function automatic int pat(int mode, int k, int c);
    case (mode)
      0: return 100 * k - 150 + ((c / 4) % 8) * 3;
      1: return ((c * 37) % 4096) - 2048;
      2: return (k % 2 == 0) ? 2047 : -2048;
      default: return ((k % 2) ? 300 : -300) + ((c / 4) % 16) * 10;
    endcase
  endfunction

  task automatic check_out();
    bit all_seen = 1;
    for (int k = 0; k < NC; k++) all_seen &= seen[k];
    if (expect_drop) begin
      chk(!out_valid, "R7", int'(out_valid), 0);
      if (exp_q[exp_core].size() > 0) void'(exp_q[exp_core].pop_front());
      exp_core = (exp_core + 1) % NC;
      expect_drop = 0;
    end else begin
      if (bg_check) begin
        chk(out_valid, "R9", int'(out_valid), 1);
        bg_check = 0;
      end
      if (out_valid) begin
        out_cnt++;
        chk(all_seen, "R2", int'(out_valid), 0);
        chk(int'(out_core) == exp_core, "R1", int'(out_core), exp_core);
        if (exp_q[exp_core].size() == 0) chk(0, "R1", int'(out_core), -1);
        else begin
          int e = exp_q[exp_core].pop_front();
          chk(int'($signed(out_data)) == e, cur_tag, int'($signed(out_data)), e);
        end
        exp_core = (exp_core + 1) % NC;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_out();
  endtask

  task automatic put(int k, int x);
    core_valid[k] = 1'b1;
    core_data[k*DW +: DW] = DW'(x);
    seen[k] = 1;
    m_acc[k] = m_acc[k] + x - (m_acc[k] >>> 10);   // R8 model
    if (bg_mode) m_off[k] = sx12(m_acc[k] >>> 10);
    exp_q[k].push_back(corr(x, m_off[k], m_gain[k]));
  endtask

  task automatic idle(int n);
    core_valid = '0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_coef(int k, int off, int g);
    coef_we = 1'b1; coef_sel = 2'(k); coef_off = DW'(off); coef_gain = GW'(g);
    if (!bg_mode) m_off[k] = off;
    m_gain[k] = g;
    tick();
    coef_we = 1'b0;
  endtask

  task automatic stream(int n, int mode, int drop_at, int bgw_at);
    steady = 0;
    for (int c = 0; c < n; c++) begin
      int k = c % NC;
      core_valid = '0;
      put(k, pat(mode, k, c));
      if (c == drop_at) begin
        coef_we = 1'b1; coef_sel = 2'd3; coef_off = DW'(m_off[3]); coef_gain = GW'(m_gain[3]);
        expect_drop = 1;
      end
      if (c == bgw_at) begin
        coef_we = 1'b1; coef_sel = 2'd1; coef_off = DW'(77); coef_gain = GW'(m_gain[1]);
        bg_check = 1;
      end
      tick();
      coef_we = 1'b0;
      if (c >= 8 && out_valid) steady++;
    end
    core_valid = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: actual %0d cycles expected fewer", 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NC; k++) begin
      m_off[k] = 0; m_gain[k] = 32768; m_acc[k] = 0; seen[k] = 0;
    end
    repeat (3) @(negedge clk);
    chk(!out_valid, "R2", int'(out_valid), 0);
    rst_n = 1'b1;
    idle(3);
    chk(!out_valid, "R2", int'(out_valid), 0);

    // R2/R1: priming with reversed arrival order
    cur_tag = "R4";
    for (int k = NC - 1; k >= 1; k--) begin
      core_valid = '0; put(k, 40 * k - 70); tick();
      chk(!out_valid, "R2", int'(out_valid), 0);
    end
    core_valid = '0; put(0, 11); tick();
    idle(2);
    chk(!out_valid || out_core == 2'd0, "R2", int'(out_valid), 0);
    idle(8);
    chk(out_cnt == 4, "R1", out_cnt, 4);

    // R3/R4: ramp with identity coefficients
    stream(64, 1, -1, -1);
    idle(8);
    chk(steady == 56, "R3", steady, 56);

    // R10: core 2 missing in a round
    out_cnt = 0;
    core_valid = '0; put(0, 5); tick();
    core_valid = '0; put(1, -6); tick();
    core_valid = '0; tick();
    put(3, 9); tick();
    idle(8);
    chk(out_cnt == 2, "R10", out_cnt, 2);
    put(2, -700); tick();
    idle(8);
    chk(out_cnt == 4, "R10", out_cnt, 4);

    // R6: per-core coefficients in foreground
    cur_tag = "R6";
    wr_coef(1, 50, 24576);
    wr_coef(2, -20, 49152);
    stream(40, 0, -1, -1);
    idle(8);

    // R5: saturation at both ends
    cur_tag = "R5";
    wr_coef(0, 0, 65535);
    wr_coef(1, 0, 65535);
    stream(24, 2, -1, -1);
    idle(8);

    // R7: foreground write during streaming drops one slot
    cur_tag = "R4";
    stream(40, 1, 21, -1);
    idle(8);

    // R8: background estimator drives offsets
    for (int k = 0; k < NC; k++) wr_coef(k, 0, 32768);
    bg_mode = 1'b1;
    cur_tag = "R8";
    stream(200, 3, -1, -1);
    idle(8);

    // R9: offset field ignored in background, no slot lost
    cur_tag = "R9";
    wr_coef(0, 500, 32768);
    stream(40, 3, -1, 17);
    idle(8);
    for (int k = 0; k < NC; k++) chk(exp_q[k].size() == 0, "R9", exp_q[k].size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule